// File: doc/BRIEF.md
# Byte-at-a-time I2C bus master

This block is an I2C master that moves exactly one byte per command. Software programs it through five small registers. It loads a byte into the data buffer and chooses the framing for that byte: whether a START goes before it, whether a STOP follows it, and, on a received byte, whether the master answers ACK or NAK. It then sets the go bit. The controller clocks the byte out or in on the bus and reports the result through status flags. Software clears those flags by writing 1 to them.

SCL and SDA are open-drain. An output of 1 on `scl_oe_o` or `sda_oe_o` pulls that line low, and an output of 0 releases it. The input pins return the resolved line levels. The SCL rate is 100 kHz in standard mode and 400 kHz in fast mode, both derived from the `CLK_HZ` parameter.

The direction of the transfer comes from the bus itself. When a byte is sent with a START, its bit 0 is latched. Every later byte sent without a START is received if that latched bit was 1, and transmitted if it was 0.

Registers are placed `STRIDE` words apart. The register index is the word address divided by `STRIDE`, and an address that is not a multiple of `STRIDE` reads as 0.

Top module: `byte_i2c_master`

## Requirements
- R1: After reset the control register (index 2) and the status register (index 3) read 0x00, and both bus lines are released.
- R2: Register index = word address / `STRIDE`. Index 4 is an 8-bit read/write own-address register. A misaligned address, or an index above 4, reads 0x00.
- R3: A byte sent with START produces a START condition (SDA falls while SCL is high) and then 8 data bits, MSB first. SDA changes only while SCL is low. The level the slave drives in the ninth clock appears in status bit 3 (1 = NAK).
- R4: When a transmitted byte, including its ninth clock, completes, status bit 0 (transmit-empty) sets. At that same point control bit 0 (go) clears.
- R5: If the START byte had bit 0 = 1, later bytes without START are received MSB first into the data buffer (index 1), and status bit 1 (receive-full) sets. In the ninth clock the master pulls SDA low, unless control bit 3 (NAK) is set, in which case it releases SDA.
- R6: Writing 1 to status bit 0 or bit 1 clears that bit. Writing 0 leaves it unchanged.
- R7: Control bit 1 (START) sets status bit 2 (busy). Control bit 2 (STOP) makes the master issue a STOP after the ninth clock, and busy clears once the STOP completes. Between bytes without STOP, SCL is held low.
- R8: SCL is high for 2·Q system clocks per bit. Q = CLK_HZ/400000 when control bit 6 = 0 (standard mode) and Q = CLK_HZ/1600000 when control bit 6 = 1 (fast mode).
- R9: Writing 1 to control bit 5 (unit reset) aborts any byte in progress, releases both lines, clears status and control bits 0 to 4, and leaves control bit 6 unchanged. The register reads back 0x20 | (bit 6).
- R10: The go bit is accepted only in a write that also sets control bit 4 (enable). Otherwise go reads 0 and the bus stays idle.
- R11: Index 0 reads {6'b0, SCL level, SDA level}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address of the register access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data (combinational from `addr`) |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
Register reads are combinational, so the bench samples `rd_data` one time unit after setting the address, away from the clock edge. Status flags are due at the end of the ninth SCL period, which is 36·Q cycles plus any START, so the bench polls the status register instead of counting cycles. It then compares the whole status byte, so busy and the ACK level are checked in the same read. A bus-side slave model pops expected bytes from a scoreboard queue as each eighth falling SCL edge arrives, and measures every SCL high phase in system clocks against the exact value 2·Q.

// File: rtl/byte_i2c_master.sv
`timescale 1ns/1ps
module byte_i2c_master #(
  parameter int CLK_HZ = 100_000_000,
  parameter int STRIDE = 1,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  localparam int QSTD  = CLK_HZ / 400_000;
  localparam int QFAST = CLK_HZ / 1_600_000;
  localparam int CW    = $clog2(QSTD + 1);
  localparam logic [AW-1:0] IX_MON  = AW'(0);
  localparam logic [AW-1:0] IX_DATA = AW'(1);
  localparam logic [AW-1:0] IX_CTRL = AW'(2);
  localparam logic [AW-1:0] IX_STAT = AW'(3);
  localparam logic [AW-1:0] IX_OWN  = AW'(4);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st_q;
  logic [1:0]    qtr_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q, dbuf_q, own_q;
  logic [CW-1:0] qcnt_q;
  logic          c_go, c_start, c_stop, c_nak, c_en, c_urst, c_fast;
  logic          s_txe, s_rxf, s_busy, s_ack;
  logic          rdmode_q, rx_q, stop_q, nak_q;

  logic          aligned;
  logic [AW-1:0] idx;
  assign aligned = (int'(addr) % STRIDE) == 0;
  assign idx     = AW'(int'(addr) / STRIDE);

  logic wr_ctl, wr_stat, wr_dat, wr_own;
  assign wr_ctl  = wr_en && aligned && idx == IX_CTRL;
  assign wr_stat = wr_en && aligned && idx == IX_STAT;
  assign wr_dat  = wr_en && aligned && idx == IX_DATA;
  assign wr_own  = wr_en && aligned && idx == IX_OWN;

  logic [CW-1:0] qlim;
  logic tick, launch, byte_end, stop_end;
  assign qlim     = c_fast ? CW'(QFAST - 1) : CW'(QSTD - 1);
  assign tick     = (st_q != S_IDLE) && (qcnt_q == qlim);
  assign launch   = (st_q == S_IDLE) && c_go && c_en && !c_urst;
  assign byte_end = tick && st_q == S_DATA && bit_q == 4'd8 && qtr_q == 2'd3;
  assign stop_end = tick && st_q == S_STOP && qtr_q == 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_go, c_start, c_stop, c_nak, c_en, c_urst, c_fast} <= '0;
    end else if (wr_ctl) begin
      if (wr_data[5]) begin
        c_urst <= 1'b1;
        {c_go, c_start, c_stop, c_nak, c_en} <= '0;
      end else begin
        c_urst  <= 1'b0;
        c_go    <= (c_go & ~byte_end) | (wr_data[0] & wr_data[4]);
        c_start <= wr_data[1];
        c_stop  <= wr_data[2];
        c_nak   <= wr_data[3];
        c_en    <= wr_data[4];
        c_fast  <= wr_data[6];
      end
    end else if (byte_end || c_urst) begin
      c_go <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_txe, s_rxf, s_busy, s_ack} <= '0;
    end else if (c_urst) begin
      {s_txe, s_rxf, s_busy, s_ack} <= '0;
    end else begin
      s_txe <= (byte_end & ~rx_q) | (s_txe & ~(wr_stat & wr_data[0]));
      s_rxf <= (byte_end &  rx_q) | (s_rxf & ~(wr_stat & wr_data[1]));
      if (launch && c_start)  s_busy <= 1'b1;
      else if (stop_end)      s_busy <= 1'b0;
      if (tick && st_q == S_DATA && bit_q == 4'd8 && qtr_q == 2'd1 && !rx_q)
        s_ack <= sda_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbuf_q <= '0;
      own_q  <= '0;
    end else begin
      if (wr_dat)                 dbuf_q <= wr_data;
      else if (byte_end && rx_q)  dbuf_q <= sh_q;
      if (wr_own)                 own_q  <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; qtr_q <= '0; bit_q <= '0; sh_q <= '0; qcnt_q <= '0;
      rdmode_q <= 1'b0; rx_q <= 1'b0; stop_q <= 1'b0; nak_q <= 1'b0;
    end else if (c_urst) begin
      st_q <= S_IDLE; qtr_q <= '0; qcnt_q <= '0; rdmode_q <= 1'b0; rx_q <= 1'b0;
    end else if (st_q == S_IDLE) begin
      if (launch) begin
        qcnt_q <= '0;
        bit_q  <= '0;
        sh_q   <= dbuf_q;
        stop_q <= c_stop;
        nak_q  <= c_nak;
        if (c_start) begin
          st_q     <= S_START;
          qtr_q    <= s_busy ? 2'd0 : 2'd1;
          rx_q     <= 1'b0;
          rdmode_q <= dbuf_q[0];
        end else begin
          st_q  <= S_DATA;
          qtr_q <= 2'd0;
          rx_q  <= rdmode_q;
        end
      end
    end else if (!tick) begin
      qcnt_q <= qcnt_q + CW'(1);
    end else begin
      qcnt_q <= '0;
      qtr_q  <= qtr_q + 2'd1;
      case (st_q)
        S_START: if (qtr_q == 2'd3) st_q <= S_DATA;
        S_DATA: begin
          if (qtr_q == 2'd1 && bit_q != 4'd8 && rx_q) sh_q <= {sh_q[6:0], sda_i};
          if (qtr_q == 2'd3) begin
            if (!rx_q) sh_q <= {sh_q[6:0], 1'b0};
            bit_q <= bit_q + 4'd1;
            if (bit_q == 4'd8) st_q <= stop_q ? S_STOP : S_IDLE;
          end
        end
        S_STOP:  if (qtr_q == 2'd3) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (st_q)
      S_IDLE:  scl_oe_o = s_busy;
      S_START: begin
        scl_oe_o = (qtr_q == 2'd0) || (qtr_q == 2'd3);
        sda_oe_o = qtr_q[1];
      end
      S_DATA: begin
        scl_oe_o = (qtr_q == 2'd0) || (qtr_q == 2'd3);
        sda_oe_o = (bit_q == 4'd8) ? (rx_q & ~nak_q) : (~rx_q & ~sh_q[7]);
      end
      S_STOP: begin
        scl_oe_o = (qtr_q == 2'd0);
        sda_oe_o = ~qtr_q[1];
      end
      default: ;
    endcase
  end

  always_comb begin
    rd_data = '0;
    if (aligned) begin
      case (idx)
        IX_MON:  rd_data = {6'b0, scl_i, sda_i};
        IX_DATA: rd_data = dbuf_q;
        IX_CTRL: rd_data = {1'b0, c_fast, c_urst, c_en, c_nak, c_stop, c_start, c_go};
        IX_STAT: rd_data = {4'b0, s_ack, s_busy, s_rxf, s_txe};
        IX_OWN:  rd_data = own_q;
        default: rd_data = '0;
      endcase
    end
  end

  // R3
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DATA && qtr_q == 2'd2) |-> $stable(sda_oe_o));
  // R4
  go_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_txe) |-> !c_go);
  // R6
  txe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_txe) |-> ($past(wr_stat && wr_data[0]) || $past(c_urst)));
  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_busy) |-> ($past(st_q == S_STOP) || $past(c_urst)));
  // R9
  unit_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_urst |=> (st_q == S_IDLE && !s_busy && !scl_oe_o && !sda_oe_o));
  // R10
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && !c_en) |=> st_q == S_IDLE);
endmodule

// File: tb/byte_i2c_master_tb_top.sv
`timescale 1ns/1ps
module byte_i2c_master_tb_top;
  localparam int CLKHZ = 8_000_000;
  localparam int STR   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  wire  [7:0] rd_data;
  wire  scl_oe, sda_oe;
  logic s_low = 1'b0;
  wire  scl = ~scl_oe;
  wire  sda = ~(sda_oe | s_low);

  byte_i2c_master #(.CLK_HZ(CLKHZ), .STRIDE(STR), .AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .scl_i(scl), .sda_i(sda), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe));

  always #2.5 clk = ~clk;
  int cyc = 0;
  always @(negedge clk) cyc++;

  int nvec = 0, nfail = 0;
  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] aof(input int ix);
    return 4'(ix * STR);
  endfunction

  task automatic wr(input int ix, input logic [7:0] d);
    @(negedge clk); addr = aof(ix); wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_raw(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1; v = rd_data;
  endtask

  task automatic rd(input int ix, output logic [7:0] v);
    rd_raw(aof(ix), v);
  endtask

  // slave model and scoreboard queues
  logic [7:0] exp_q[$];
  logic [7:0] stx_q[$];
  logic       mack_q[$];
  bit active = 0, reading = 0, addrph = 0, snak = 0;
  int bitc = 0, stops = 0, t_hi = 0, hi_len = 0;
  logic [7:0] sh = '0, txb = '0;

  always @(negedge sda) if (scl) begin
    active = 1; bitc = 0; addrph = 1; reading = 0; s_low = 0;
  end
  always @(posedge sda) if (scl && active) begin
    stops++; active = 0; s_low = 0;
  end
  always @(posedge scl) begin
    t_hi = cyc;
    if (active) begin
      if (bitc < 8) sh = {sh[6:0], sda};
      else if (bitc == 8 && reading && !addrph) begin
        if (mack_q.size() == 0) check("R5 unexpected master ack", 1, 0);
        else check("R5 master ack level", int'(sda), int'(mack_q.pop_front()));
        if (sda) reading = 0;
      end
      bitc++;
    end
  end
  always @(negedge scl) begin
    hi_len = cyc - t_hi;
    if (active) begin
      if (bitc == 8) begin
        if (!reading) begin
          if (exp_q.size() == 0) check("R3 unexpected byte on bus", int'(sh), 0);
          else check("R3 byte seen by slave", int'(sh), int'(exp_q.pop_front()));
          if (addrph) reading = sh[0];
          s_low = !snak;
        end else s_low = 0;
      end else if (bitc == 9) begin
        bitc = 0; addrph = 0;
        if (reading) begin
          txb = (stx_q.size() != 0) ? stx_q.pop_front() : 8'hFF;
          s_low = !txb[7];
        end else s_low = 0;
      end else if (reading && bitc >= 1 && bitc <= 7) s_low = !txb[7 - bitc];
    end
  end

  bit fast = 0;
  task automatic wait_stat(input int b, input logic want, input string req);
    logic [7:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(3, v);
      if (v[b] == want) return;
    end
    check({req, " status wait timeout"}, 0, 1);
  endtask

  task automatic tx_byte(input logic [7:0] d, input bit st, input bit sp, input bit nak);
    snak = nak;
    exp_q.push_back(d);
    wr(1, d);
    wr(2, {1'b0, fast, 1'b0, 1'b1, 1'b0, sp, st, 1'b1});
    wait_stat(0, 1'b1, "R4");
  endtask

  task automatic rx_byte(input bit nak, input bit sp);
    wr(2, {1'b0, fast, 1'b0, 1'b1, nak, sp, 1'b0, 1'b1});
    wait_stat(1, 1'b1, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(2, v); check("R1 control after reset", v, 8'h00);
    rd(3, v); check("R1 status after reset", v, 8'h00);
    check("R1 lines released", {scl, sda}, 2'b11);
    // R11
    rd(0, v); check("R11 bus monitor idle", v, 8'h03);
    // R2
    wr(4, 8'hA7); rd(4, v); check("R2 own address readback", v, 8'hA7);
    rd_raw(4'd3, v); check("R2 misaligned read", v, 8'h00);
    rd(7, v); check("R2 unmapped index read", v, 8'h00);
    // R10
    wr(2, 8'h07); rd(2, v); check("R10 go refused without enable", v, 8'h06);
    repeat (100) @(negedge clk);
    check("R10 bus untouched", {scl, sda}, 2'b11);
    rd(3, v); check("R10 status untouched", v, 8'h00);

    // write transfer, standard mode
    tx_byte(8'hA4, 1, 0, 0);
    rd(3, v); check("R3 R7 status after addressed byte", v, 8'h05);
    rd(2, v); check("R4 go self-cleared", int'(v[0]), 0);
    check("R7 scl held low between bytes", int'(scl), 0);
    rd(0, v); check("R11 bus monitor sees scl low", int'(v[1]), 0);
    wr(3, 8'h00); rd(3, v); check("R6 write 0 keeps flag", v, 8'h05);
    wr(3, 8'h01); rd(3, v); check("R6 write 1 clears flag", v, 8'h04);
    tx_byte(8'h3C, 0, 0, 1);
    rd(3, v); check("R3 NAK recorded", v, 8'h0D);
    wr(3, 8'h01);
    tx_byte(8'h81, 0, 1, 0);
    wait_stat(2, 1'b0, "R7");
    rd(3, v); check("R7 busy cleared after STOP", v, 8'h01);
    check("R7 STOP seen on bus", stops, 1);
    check("R7 lines released after STOP", {scl, sda}, 2'b11);
    check("R8 standard SCL high time", hi_len, 2 * (CLKHZ / 400_000));
    wr(3, 8'h01);

    // read transfer, fast mode
    fast = 1;
    stx_q.push_back(8'h96); stx_q.push_back(8'h3B);
    mack_q.push_back(1'b0); mack_q.push_back(1'b1);
    tx_byte(8'hA5, 1, 0, 0);
    wr(3, 8'h01);
    rx_byte(0, 0);
    rd(1, v); check("R5 first received byte", v, 8'h96);
    rd(3, v); check("R5 status after receive", v, 8'h06);
    wr(3, 8'h02); rd(3, v); check("R6 receive flag cleared", v, 8'h04);
    rx_byte(1, 1);
    wait_stat(2, 1'b0, "R7");
    rd(1, v); check("R5 last received byte", v, 8'h3B);
    check("R7 second STOP seen", stops, 2);
    check("R8 fast SCL high time", hi_len, 2 * (CLKHZ / 1_600_000));
    wr(3, 8'h03);

    // R9 abort mid-byte
    wr(1, 8'h55);
    wr(2, 8'h53);
    repeat (60) @(negedge clk);
    check("R9 transfer in progress", int'(scl_oe | sda_oe) | int'(!scl), 1);
    wr(2, 8'h20);
    rd(2, v); check("R9 control after unit reset", v, 8'h60);
    rd(3, v); check("R9 status after unit reset", v, 8'h00);
    check("R9 lines released", {scl, sda}, 2'b11);

    check("R3 scoreboard drained", exp_q.size(), 0);
    check("R5 master ack queue drained", mack_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule